// File: doc/BRIEF.md
# Crossbar Slave-Port Priority Arbiter

This block decides which master of a multi-master crossbar may use one slave port. Up to six masters each raise a request with a 32-bit address. A small register file holds one programmed priority for each master. The requesting master with the highest effective priority wins. When effective priorities are equal, the master with the lower index wins. Any master enabled by the `ELEV_MASK` parameter can be raised to the top priority level for as long as its elevation input is high. When elevation drops, the master's programmed priority applies again.

Arbitration happens only at transfer boundaries. These are the cycles in which the port is idle, and the cycle in which the slave pulses `xfer_done` on the current transfer. A winner chosen in a `xfer_done` cycle owns the port in the very next cycle, so back-to-back transfers need no idle cycle. This holds whether the same master wins again or a different one does. With no requests pending, the grant is released and the index stays parked on the last owner. The index and the selected address drive the data-path multiplexer of the slave port. Contention at other slaves is resolved by their own copies of this block.

Top module: `xbar_slave_arb`

## Requirements
- R1: After reset, `gnt_valid` is 0, `gnt` is 0, `gnt_idx` is 0, and every programmed priority reads back as 0.
- R2: At an arbitration point, the requesting master with the numerically highest effective priority is granted. The grant appears in the cycle after the request is sampled.
- R3: Among requesters with equal effective priority, the lowest master index is granted.
- R4: A master whose `ELEV_MASK` bit is 1 and whose `elev` bit is 1 has an effective priority of 2^PRIO_W-1 (7 by default). A master with a mask bit of 0 is unaffected by `elev`. After `elev` drops, the programmed value applies again. The default mask enables masters 2 and 3.
- R5: While `gnt_valid` is 1 and `xfer_done` is 0, the grant does not change, even if requests of higher priority arrive.
- R6: If `xfer_done` is 1 while a master is granted and any request is present, `gnt_valid` stays 1 in the next cycle, granted to the new winner. The new winner may be the same master.
- R7: If no request is present at an arbitration point, `gnt_valid` goes to 0 and `gnt_idx` keeps the last granted index.
- R8: When `cfg_we` is 1 at a clock edge, `cfg_wdata` is stored as the priority of master `cfg_sel`. A `cfg_sel` value of `N_MST` or above is ignored for writes and reads back as 0. `cfg_rdata` shows the priority of master `cfg_sel` combinationally.
- R9: `gnt_addr` equals the address of master `gnt_idx`, taken from bits `[32*i+31:32*i]` of `addr`.
- R10: `gnt` is one-hot, with bit `gnt_idx` set, while `gnt_valid` is 1. It is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_MST | Request, one bit per master (bit i is master i) |
| addr | input | N_MST*ADDR_W | Address of each master, master i in slice i |
| elev | input | N_MST | Priority elevation request for each master |
| xfer_done | input | 1 | Slave ends the current transfer this cycle |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_sel | input | IDX_W | Master selected for priority write and read |
| cfg_wdata | input | PRIO_W | Priority value to write |
| cfg_rdata | output | PRIO_W | Priority of the selected master |
| gnt | output | N_MST | One-hot grant |
| gnt_valid | output | 1 | Slave port is owned by a master |
| gnt_idx | output | IDX_W | Granted or parked master index |
| gnt_addr | output | ADDR_W | Address of the granted master |

## Verification
The properties assume that `xfer_done` is pulsed only while a master holds the grant, and that `cfg_sel` stays at or below 7. The stimulus raises `xfer_done` only after a checked grant. It either drops all requests at the same time or presents the next set for a back-to-back transfer. Priority writes are made while the port is idle, so the ranking properties see stable priorities. Elevation is applied on masters both inside and outside the mask, so that R4 is checked against its real effect on the grant.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  localparam int PRIO_MAX_W = 8;

  // candidate (pa, ia) beats incumbent (pb, ib): higher level, then lower index
  function automatic logic outranks(input logic [PRIO_MAX_W-1:0] pa, input int ia,
                                    input logic [PRIO_MAX_W-1:0] pb, input int ib);
    return (pa > pb) || ((pa == pb) && (ia < ib));
  endfunction

  // effective level of one master
  function automatic logic [PRIO_MAX_W-1:0] eff_level(input logic [PRIO_MAX_W-1:0] prog,
                                                      input logic boost,
                                                      input logic [PRIO_MAX_W-1:0] top);
    return boost ? top : prog;
  endfunction
endpackage

// File: rtl/xbar_prio_regs.sv
module xbar_prio_regs #(
  parameter int N_MST = 6,
  parameter int PRIO_W = 3,
  parameter logic [N_MST-1:0] ELEV_MASK = '0,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_sel,
  input  logic [PRIO_W-1:0]       cfg_wdata,
  input  logic [N_MST-1:0]        elev,
  output logic [PRIO_W-1:0]       cfg_rdata,
  output logic [N_MST*PRIO_W-1:0] eff_prio
);
  import xbar_arb_pkg::*;
  localparam logic [PRIO_MAX_W-1:0] TOP_LVL = PRIO_MAX_W'((1 << PRIO_W) - 1);

  logic [PRIO_W-1:0] prio_q [N_MST];
  logic              sel_ok;

  assign sel_ok = int'(cfg_sel) < N_MST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_MST; i++) prio_q[i] <= '0;
    end else if (cfg_we && sel_ok) begin
      prio_q[cfg_sel] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < N_MST; i++)
      if (int'(cfg_sel) == i) cfg_rdata = prio_q[i];
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_eff
    logic [PRIO_MAX_W-1:0] lvl;
    assign lvl = eff_level(PRIO_MAX_W'(prio_q[g]), elev[g] & ELEV_MASK[g], TOP_LVL);
    assign eff_prio[g*PRIO_W +: PRIO_W] = lvl[PRIO_W-1:0];
  end
endmodule

// File: rtl/xbar_prio_pick.sv
module xbar_prio_pick #(
  parameter int N_MST = 6,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0]        req,
  input  logic [N_MST*PRIO_W-1:0] eff_prio,
  output logic                    pick_valid,
  output logic [IDX_W-1:0]        pick_idx
);
  import xbar_arb_pkg::*;

  logic [PRIO_MAX_W-1:0] best_p;
  int                    best_i;

  always_comb begin
    pick_valid = 1'b0;
    best_p     = '0;
    best_i     = N_MST;
    for (int i = 0; i < N_MST; i++) begin
      if (req[i] && (!pick_valid ||
          outranks(PRIO_MAX_W'(eff_prio[i*PRIO_W +: PRIO_W]), i, best_p, best_i))) begin
        pick_valid = 1'b1;
        best_p     = PRIO_MAX_W'(eff_prio[i*PRIO_W +: PRIO_W]);
        best_i     = i;
      end
    end
    pick_idx = pick_valid ? IDX_W'(best_i) : '0;
  end
endmodule

// File: rtl/xbar_grant_hold.sv
module xbar_grant_hold #(
  parameter int N_MST = 6,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             xfer_done,
  output logic             busy,
  output logic [IDX_W-1:0] owner,
  output logic             arb_open
);
  assign arb_open = !busy || xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (arb_open) begin
      busy <= pick_valid;
      if (pick_valid) owner <= pick_idx;
    end
  end
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb #(
  parameter int N_MST = 6,
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 3,
  parameter logic [N_MST-1:0] ELEV_MASK = 6'b001100,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        req,
  input  logic [N_MST*ADDR_W-1:0] addr,
  input  logic [N_MST-1:0]        elev,
  input  logic                    xfer_done,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_sel,
  input  logic [PRIO_W-1:0]       cfg_wdata,
  output logic [PRIO_W-1:0]       cfg_rdata,
  output logic [N_MST-1:0]        gnt,
  output logic                    gnt_valid,
  output logic [IDX_W-1:0]        gnt_idx,
  output logic [ADDR_W-1:0]       gnt_addr
);
  logic [N_MST*PRIO_W-1:0] eff_prio;
  logic                    pick_valid;
  logic [IDX_W-1:0]        pick_idx;
  logic                    busy;
  logic                    arb_open;
  logic [IDX_W-1:0]        owner;

  xbar_prio_regs #(.N_MST(N_MST), .PRIO_W(PRIO_W), .ELEV_MASK(ELEV_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .elev(elev), .cfg_rdata(cfg_rdata), .eff_prio(eff_prio)
  );

  xbar_prio_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
    .req(req), .eff_prio(eff_prio), .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  xbar_grant_hold #(.N_MST(N_MST)) u_hold (
    .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .xfer_done(xfer_done), .busy(busy), .owner(owner), .arb_open(arb_open)
  );

  assign gnt_valid = busy;
  assign gnt_idx   = owner;

  always_comb begin
    gnt_addr = '0;
    for (int i = 0; i < N_MST; i++)
      if (int'(owner) == i) gnt_addr = addr[i*ADDR_W +: ADDR_W];
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_gnt
    assign gnt[g] = busy && (int'(owner) == g);
  end
endmodule

// File: rtl/xbar_slave_arb_chk.sv
module xbar_slave_arb_chk #(
  parameter int N_MST = 6,
  parameter int PRIO_W = 3,
  parameter logic [N_MST-1:0] ELEV_MASK = '0,
  parameter int IDX_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_MST-1:0]        req,
  input logic [N_MST-1:0]        elev,
  input logic                    xfer_done,
  input logic [N_MST-1:0]        gnt,
  input logic                    gnt_valid,
  input logic [IDX_W-1:0]        gnt_idx,
  input logic [N_MST*PRIO_W-1:0] eff_prio,
  input logic                    pick_valid,
  input logic [IDX_W-1:0]        pick_idx
);
  localparam logic [PRIO_W-1:0] TOP_LVL = PRIO_W'((1 << PRIO_W) - 1);

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r10_match: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt[gnt_idx] && $countones(gnt) == 1));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_idx)));
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done && (|req)) |=> gnt_valid);
  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && !(|req)) |=> (!gnt_valid && $stable(gnt_idx)));

  for (genvar j = 0; j < N_MST; j++) begin : g_rank
    a_r2_rank: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && req[j]) |->
        (eff_prio[pick_idx*PRIO_W +: PRIO_W] >= eff_prio[j*PRIO_W +: PRIO_W]));
    a_r3_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && req[j] && (IDX_W'(j) < pick_idx)) |->
        (eff_prio[j*PRIO_W +: PRIO_W] < eff_prio[pick_idx*PRIO_W +: PRIO_W]));
    if (ELEV_MASK[j]) begin : g_el
      a_r4_elev_top: assert property (@(posedge clk) disable iff (!rst_n)
        elev[j] |-> (eff_prio[j*PRIO_W +: PRIO_W] == TOP_LVL));
    end
  end
endmodule

bind xbar_slave_arb xbar_slave_arb_chk #(
  .N_MST(N_MST), .PRIO_W(PRIO_W), .ELEV_MASK(ELEV_MASK), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .elev(elev), .xfer_done(xfer_done),
  .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .eff_prio(eff_prio),
  .pick_valid(pick_valid), .pick_idx(pick_idx)
);

// File: tb/xbar_slave_arb_bench.sv
`timescale 1ns/1ps
module xbar_slave_arb_bench;
  localparam int N = 6;
  localparam int AW = 32;
  localparam int PW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*AW-1:0] addr;
  logic [N-1:0]  elev = '0;
  logic          xfer_done = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic [PW-1:0] cfg_rdata;
  logic [N-1:0]  gnt;
  logic          gnt_valid;
  logic [IW-1:0] gnt_idx;
  logic [AW-1:0] gnt_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_addr
    assign addr[g*AW +: AW] = 32'hA000_0000 + 32'(g * 16);
  end

  xbar_slave_arb u_xbar_slave_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .elev(elev),
    .xfer_done(xfer_done), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
    .gnt_addr(gnt_addr)
  );

  // programmed levels used throughout: m0=1 m1=3 m2=2 m3=5 m4=5 m5=0
  localparam logic [PW-1:0] PROG [N] = '{3'd1, 3'd3, 3'd2, 3'd5, 3'd5, 3'd0};

  // {req[5:0], elev[5:0], expected winner}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {6'b000001, 6'b000000, 3'd0},
    {6'b000011, 6'b000000, 3'd1},
    {6'b011000, 6'b000000, 3'd3},
    {6'b111111, 6'b000000, 3'd3},
    {6'b000101, 6'b000100, 3'd2},
    {6'b011100, 6'b000100, 3'd2},
    {6'b110000, 6'b000000, 3'd4},
    {6'b000011, 6'b000001, 3'd1},
    {6'b001100, 6'b001100, 3'd2},
    {6'b100000, 6'b000000, 3'd5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input int sel, input int val);
    cfg_sel = IW'(sel); cfg_wdata = PW'(val); cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic expect_grant(input string tag, input int idx);
    chk({tag, " valid"}, 32'(gnt_valid), 32'd1);
    chk({tag, " idx"}, 32'(gnt_idx), 32'(idx));
    chk({"R10 onehot"}, 32'(gnt), 32'(1 << idx));
    chk({"R9 addr"}, gnt_addr, 32'hA000_0000 + 32'(idx * 16));
  endtask

  task automatic finish_idle();
    req = '0; elev = '0; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    chk("R1 valid", 32'(gnt_valid), 32'd0);
    chk("R1 gnt", 32'(gnt), 32'd0);
    chk("R1 idx", 32'(gnt_idx), 32'd0);
    for (int i = 0; i < N; i++) begin
      cfg_sel = IW'(i); #1;
      chk("R1 prio", 32'(cfg_rdata), 32'd0);
    end
    for (int i = 0; i < N; i++) wr(i, int'(PROG[i]));

    // R2 R3 R4 table walk
    for (int v = 0; v < NV; v++) begin
      req = VEC[v][14:9]; elev = VEC[v][8:3];
      tick();
      expect_grant("R2 R3 R4 table", int'(VEC[v][2:0]));
      finish_idle();
      chk("R7 release", 32'(gnt_valid), 32'd0);
    end

    // R5: grant held against stronger requests
    req = 6'b100000;
    tick();
    expect_grant("R5 start", 5);
    req = 6'b111111; elev = 6'b001100;
    for (int k = 0; k < 3; k++) begin
      tick();
      expect_grant("R5 hold", 5);
    end
    // R6: new owner without idle cycle
    req = 6'b000100; elev = '0; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    expect_grant("R6 switch", 2);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    expect_grant("R6 same master", 2);
    // R7: park
    finish_idle();
    chk("R7 valid", 32'(gnt_valid), 32'd0);
    chk("R7 parked idx", 32'(gnt_idx), 32'd2);
    chk("R10 no grant", 32'(gnt), 32'd0);
    tick();
    chk("R7 still parked", 32'(gnt_idx), 32'd2);

    // R4: restore after elevation drops
    req = 6'b000110; elev = 6'b000100;
    tick();
    expect_grant("R4 boosted", 2);
    elev = '0; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    expect_grant("R4 restored", 1);
    finish_idle();

    // R8: out-of-range select ignored, writes take effect
    wr(6, 7);
    for (int i = 0; i < N; i++) begin
      cfg_sel = IW'(i); #1;
      chk("R8 readback", 32'(cfg_rdata), 32'(PROG[i]));
    end
    cfg_sel = 3'd6; #1;
    chk("R8 sel6 reads 0", 32'(cfg_rdata), 32'd0);
    wr(0, 7);
    cfg_sel = 3'd0; #1;
    chk("R8 write", 32'(cfg_rdata), 32'd7);
    req = 6'b000011;
    tick();
    expect_grant("R8 new level", 0);
    finish_idle();

    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule